// File: doc/BRIEF.md
# Hall Commutation and Drive Gating

This block turns three digital Hall sensor levels and a rotation-direction level into the six gate enables of a three-phase bridge. Each phase has one high-side enable and one low-side enable. The Hall code selects one phase to source current through its high-side switch and one phase to sink current through its low-side switch. Setting the direction input swaps the rotation sense by using the bitwise complement of the Hall code in the lookup. The codes 000 and 111 cannot occur on a healthy sensor set, so they drive nothing.

The active step is then gated by four inputs: a run level, a PWM level, a current-limit flag and a lock-protection latch. PWM chopping and the current limiter act on the low side only, and the high-side switch of the active step stays fully on. A current-limit event blanks the low side until the PWM high interval ends. The protection latch holds every low-side switch off. A stop forces all six enables off.

When the synchronized direction changes, the bridge is held fully off for a parameterised blanking window before the new step is driven. This prevents shoot-through during reversal. Hall and direction inputs are asynchronous and pass through two-flop synchronizers. The other inputs are synchronous to the block clock.

Top module: `hall_commutator`

## Requirements
- R1: Decoding with direction low (`hall_i` = {sensor3, sensor2, sensor1}; in `hs_o`/`ls_o`, bit i drives phase i+1): 101 gives hs=010, ls=001; 001 gives hs=100, ls=001; 011 gives hs=100, ls=010; 010 gives hs=001, ls=010; 110 gives hs=001, ls=100; 100 gives hs=010, ls=100.
- R2: With direction high, each step in R1 is selected by the bitwise complement of its direction-low `hall_i` code.
- R3: The Hall codes 000 and 111 force all six outputs to 0, in either direction.
- R4: While `pwm_i` is low, the low-side output of the active step is off and its high-side output stays on. While `pwm_i` is high, the low-side output of the active step is on.
- R5: When `ilim_i` is high, the low side is off on the next cycle. When `ilim_i` is seen high while `pwm_i` is high, the low side stays off until `pwm_i` has been low for at least one cycle, even if `ilim_i` has dropped. The high side is not affected.
- R6: While `lock_i` is high, all low-side outputs are off and the high-side output of the active step is unchanged.
- R7: While `run_i` is low, all six outputs are off.
- R8: When `dir_i` toggles, the outputs are all off from the 3rd through the (BLANK_CYC+3)th rising edge after the change. The new-direction step appears at edge BLANK_CYC+4, which is edge 20 with the default of 16.
- R9: At most one high-side and one low-side output are on at any time, and never both outputs of the same phase.
- R10: Latency is 3 clock edges from `hall_i` to the outputs and 1 edge from `run_i`, `pwm_i`, `ilim_i` and `lock_i` to the outputs.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Hall sensor levels {s3, s2, s1}, asynchronous |
| dir_i | input | 1 | Rotation direction, asynchronous |
| run_i | input | 1 | 1 = run, 0 = stop (all off) |
| pwm_i | input | 1 | PWM level applied to the low side |
| ilim_i | input | 1 | Current-limit flag |
| lock_i | input | 1 | Lock-protection latch, turns off the low side |
| hs_o | output | 3 | High-side gate enables, one per phase |
| ls_o | output | 3 | Low-side gate enables, one per phase |

## Verification
The table is walked through all six valid codes in each direction, plus both invalid codes. This separates a wrong source or sink assignment from a missing complement in reverse. Directed patterns then step `pwm_i` low and high, pulse `ilim_i` briefly inside a PWM high interval, and assert `lock_i` and a stop. These show that only the low side is gated and that the cut persists until the PWM interval ends. A direction reversal is sampled exactly one edge before and one edge after the blanking window closes, which exposes any off-by-one in the window length.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int unsigned NPH = 3;
  typedef logic [NPH-1:0] phase_vec_t;

  typedef struct packed {
    logic       valid;
    phase_vec_t src;
    phase_vec_t snk;
  } step_t;
endpackage

// File: rtl/hc_sync.sv
module hc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hc_step_decode.sv
module hc_step_decode
  import hc_pkg::*;
(
  input  logic [NPH-1:0] hall_i,
  input  logic           dir_i,
  output step_t          step_o
);
  logic [NPH-1:0] code;

  // reverse rotation uses the complemented code
  assign code = dir_i ? ~hall_i : hall_i;

  always_comb begin
    step_o = '0;
    unique case (code)
      3'b101: step_o = '{1'b1, 3'b010, 3'b001};
      3'b001: step_o = '{1'b1, 3'b100, 3'b001};
      3'b011: step_o = '{1'b1, 3'b100, 3'b010};
      3'b010: step_o = '{1'b1, 3'b001, 3'b010};
      3'b110: step_o = '{1'b1, 3'b001, 3'b100};
      3'b100: step_o = '{1'b1, 3'b010, 3'b100};
      default: step_o = '0;
    endcase
  end
endmodule

// File: rtl/hc_blank.sv
module hc_blank #(
  parameter int unsigned BLANK_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);

  logic          dir_q;
  logic          chg;
  logic [CW-1:0] cnt_q;

  assign chg    = dir_i ^ dir_q;
  assign busy_o = chg | (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      dir_q <= dir_i;
      if (chg) cnt_q <= CW'(BLANK_CYC);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8: a change starts a window that the counter then carries
  p_blank_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (cnt_q == CW'(BLANK_CYC)) && busy_o);
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(BLANK_CYC));
endmodule

// File: rtl/hc_drive_gate.sv
module hc_drive_gate
  import hc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  step_t          step_i,
  input  logic           blank_i,
  input  logic           run_i,
  input  logic           pwm_i,
  input  logic           ilim_i,
  input  logic           lock_i,
  output logic [NPH-1:0] hs_o,
  output logic [NPH-1:0] ls_o
);
  logic cut_q;
  logic ls_en;
  logic drive_ok;

  assign drive_ok = run_i & ~blank_i & step_i.valid;
  assign ls_en    = pwm_i & ~ilim_i & ~cut_q & ~lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cut_q <= 1'b0;
      hs_o  <= '0;
      ls_o  <= '0;
    end else begin
      // limiter cut lasts until the PWM high interval ends
      cut_q <= pwm_i & (cut_q | ilim_i);
      if (drive_ok) begin
        hs_o <= step_i.src;
        ls_o <= step_i.snk & {NPH{ls_en}};
      end else begin
        hs_o <= '0;
        ls_o <= '0;
      end
    end
  end

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hs_o) && $onehot0(ls_o) && ((hs_o & ls_o) == '0));
  p_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (hs_o == '0) && (ls_o == '0));
  p_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ls_o == '0);
  p_pwm_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> ls_o == '0);
  p_ilim_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_i |=> ls_o == '0);
  p_cut_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilim_i && pwm_i) ##1 pwm_i |=> ls_o == '0);
  p_blank_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (hs_o == '0) && (ls_o == '0));
  p_ls_has_hs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_o != '0) |-> ($countones(hs_o) == 1));
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
#(
  parameter int unsigned BLANK_CYC   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  input  logic       run_i,
  input  logic       pwm_i,
  input  logic       ilim_i,
  input  logic       lock_i,
  output logic [2:0] hs_o,
  output logic [2:0] ls_o
);
  localparam int unsigned SW = NPH + 1;

  logic [SW-1:0] sync_q;
  logic          blank;
  step_t         step;

  hc_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dir_i, hall_i}),
    .q_o   (sync_q)
  );

  hc_step_decode u_dec (
    .hall_i(sync_q[NPH-1:0]),
    .dir_i (sync_q[NPH]),
    .step_o(step)
  );

  hc_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dir_i (sync_q[NPH]),
    .busy_o(blank)
  );

  hc_drive_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .blank_i(blank),
    .run_i  (run_i),
    .pwm_i  (pwm_i),
    .ilim_i (ilim_i),
    .lock_i (lock_i),
    .hs_o   (hs_o),
    .ls_o   (ls_o)
  );

  // R3: the invalid codes never reach the bridge
  p_invalid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sync_q[NPH-1:0] == 3'b000) || (sync_q[NPH-1:0] == 3'b111)) |=>
      (hs_o == '0) && (ls_o == '0));
endmodule

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned BLANK = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic       dir = 1'b0, run = 1'b1, pwm = 1'b1, ilim = 1'b0, lock = 1'b0;
  logic [2:0] hs, ls;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hall_commutator #(.BLANK_CYC(BLANK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .dir_i(dir), .run_i(run),
    .pwm_i(pwm), .ilim_i(ilim), .lock_i(lock), .hs_o(hs), .ls_o(ls)
  );

  // {dir, hall, exp_hs, exp_ls}
  localparam logic [9:0] VEC [14] = '{
    {1'b0, 3'b101, 3'b010, 3'b001}, {1'b0, 3'b001, 3'b100, 3'b001},
    {1'b0, 3'b011, 3'b100, 3'b010}, {1'b0, 3'b010, 3'b001, 3'b010},
    {1'b0, 3'b110, 3'b001, 3'b100}, {1'b0, 3'b100, 3'b010, 3'b100},
    {1'b1, 3'b010, 3'b010, 3'b001}, {1'b1, 3'b110, 3'b100, 3'b001},
    {1'b1, 3'b100, 3'b100, 3'b010}, {1'b1, 3'b101, 3'b001, 3'b010},
    {1'b1, 3'b001, 3'b001, 3'b100}, {1'b1, 3'b011, 3'b010, 3'b100},
    {1'b1, 3'b000, 3'b000, 3'b000}, {1'b1, 3'b111, 3'b000, 3'b000}
  };

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {hs,ls} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    hall = 3'b101;
    waitn(3);
    check("R11 reset", {hs, ls}, 6'b0);
    rst_n = 1'b1;
    waitn(24);

    for (int i = 0; i < 14; i++) begin
      dir  = VEC[i][9];
      hall = VEC[i][8:6];
      waitn(24);
      check(i < 6 ? "R1 table" : (i < 12 ? "R2 reverse" : "R3 invalid"),
            {hs, ls}, VEC[i][5:0]);
    end

    // R10: hall latency of 3 edges (dir high)
    hall = 3'b100;
    waitn(24);
    hall = 3'b101;
    waitn(2);
    check("R10 hall latency before", {hs, ls}, 6'b100_010);
    waitn(1);
    check("R10 hall latency at 3", {hs, ls}, 6'b001_010);

    // R4: pwm low keeps high side only
    pwm = 1'b0;
    waitn(1);
    check("R4 pwm low", {hs, ls}, 6'b001_000);
    pwm = 1'b1;
    waitn(1);
    check("R4 pwm high", {hs, ls}, 6'b001_010);

    // R5: limiter cut persists to end of pwm interval
    ilim = 1'b1;
    waitn(1);
    check("R5 ilim", {hs, ls}, 6'b001_000);
    ilim = 1'b0;
    waitn(1);
    check("R5 cut hold", {hs, ls}, 6'b001_000);
    waitn(2);
    check("R5 cut hold later", {hs, ls}, 6'b001_000);
    pwm = 1'b0;
    waitn(1);
    pwm = 1'b1;
    waitn(1);
    check("R5 resume", {hs, ls}, 6'b001_010);

    // R6: lock
    lock = 1'b1;
    waitn(1);
    check("R6 lock", {hs, ls}, 6'b001_000);
    lock = 1'b0;
    waitn(1);
    check("R6 unlock", {hs, ls}, 6'b001_010);

    // R7: stop
    run = 1'b0;
    waitn(1);
    check("R7 stop", {hs, ls}, 6'b0);
    run = 1'b1;
    waitn(1);
    check("R7 run", {hs, ls}, 6'b001_010);

    // R8: reverse to dir low, hall 101 gives hs=010 ls=001
    dir = 1'b0;
    waitn(3);
    check("R8 blank start", {hs, ls}, 6'b0);
    waitn(BLANK);
    check("R8 blank last", {hs, ls}, 6'b0);
    waitn(1);
    check("R8 new step", {hs, ls}, 6'b010_001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule